// File: doc/BRIEF.md
# Branch Trace Capture Unit

This unit keeps a record of the most recent control-flow discontinuity so that a debugger can see where execution was just before it jumped. Each qualifying branch event is reported by a one-cycle strobe with an event type. While tracing is enabled, the unit samples three things on that strobe. The target fetch address goes into a destination register. The last fetch-word address before the jump goes into a source register. The count of instructions issued from that fetch word goes into a pointer register.

Instructions are 16 bits wide and fetch words are 32 bits. The exact address of the instruction that executed just before the discontinuity is therefore rebuilt from the stored word address minus two bytes per pointer step. This rebuilt address is computed combinationally and comes with a valid bit. One exception applies. For a delayed branch whose target is at an address of the form 4n+2, the source register holds the target address itself and the pointer holds zero. The reconstruction is then not applied and the valid bit is low. Bit 1 of the source register marks this case, because an ordinary capture never leaves that bit set.

Top module: `branch_trace_capture`

## Requirements
- R1: After reset, srcAddr, dstAddr and ptrVal are all zero, priorAddr is zero and priorValid is 0.
- R2: When traceEn is 0, or when brKind is 3 (reserved), a strobe changes none of srcAddr, dstAddr or ptrVal.
- R3: brKind 0 (branch), 1 (repeat loop return) and 2 (interrupt) each cause a capture when brStrobe and traceEn are both 1. The new values appear on the outputs one clock edge after the strobe.
- R4: On a capture, dstAddr becomes fetchAddr with bit 0 forced to 0.
- R5: On an ordinary capture, srcAddr becomes prevFetchAddr with bits 1 and 0 forced to 0, and ptrVal becomes issueCnt.
- R6: On a capture with delayedBr 1 and fetchAddr bit 1 equal to 1, srcAddr becomes fetchAddr with bit 0 forced to 0 and ptrVal becomes 0. With delayedBr 1 and fetchAddr bit 1 equal to 0, the capture follows R5.
- R7: When srcAddr bit 1 is 0, priorAddr equals srcAddr minus two times ptrVal, modulo 2^32. When srcAddr bit 1 is 1, priorAddr equals srcAddr.
- R8: priorValid is 1 only after at least one capture, and only while srcAddr bit 1 is 0.
- R9: Each capture overwrites all three registers in the same cycle. Nothing from the previous capture survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceEn | input | 1 | Tracing enable |
| brStrobe | input | 1 | Branch event strobe, one cycle per event |
| brKind | input | 2 | Event type: 0 branch, 1 repeat return, 2 interrupt, 3 reserved |
| fetchAddr | input | 32 | Fetch address of the branch target |
| prevFetchAddr | input | 32 | Last fetch address before the branch |
| issueCnt | input | 2 | Instructions issued from the last fetch word |
| delayedBr | input | 1 | Event is a delayed branch with a delay slot |
| srcAddr | output | 32 | Captured source address |
| dstAddr | output | 32 | Captured destination address |
| ptrVal | output | 2 | Captured pointer |
| priorAddr | output | 32 | Rebuilt address of the instruction before the branch |
| priorValid | output | 1 | priorAddr is meaningful |

## Verification
The bench covers a delayed branch to a 4n+2 target, where a wrong design would store the old fetch word or apply the subtraction and report a false valid address. It also drives a delayed branch to a 4n target, where a design that keyed only on delayedBr would wrongly take the special path. The bench forces a reconstruction to wrap below address zero with a pointer of 3, which exposes a truncated or sign-confused subtractor. It also sends strobes with tracing off and with the reserved type, where a design that leaked either one would overwrite the record.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;
  localparam int ADDR_W = 32;
  localparam int PTR_W  = 2;
  localparam int KIND_W = 2;
  localparam logic [KIND_W-1:0] KIND_RSVD = 2'd3;

  typedef struct packed {
    logic capture;
    logic useTarget;
  } brStrobes_t;
endpackage

// File: rtl/brtrace_ctl.sv
module brtrace_ctl
  import brtrace_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceEn,
  input  logic              brStrobe,
  input  logic [KIND_W-1:0] brKind,
  input  logic              delayedBr,
  input  logic              targetHalfBit,
  output brStrobes_t        strobes
);
  logic kindOk;

  always_comb begin
    kindOk            = (brKind != KIND_RSVD);
    strobes.capture   = traceEn & brStrobe & kindOk;
    strobes.useTarget = strobes.capture & delayedBr & targetHalfBit;
  end

  // R2
  gated_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> (traceEn && brKind != KIND_RSVD));

  // R6
  target_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.useTarget |-> (strobes.capture && delayedBr));
endmodule

// File: rtl/brtrace_dp.sv
module brtrace_dp
  import brtrace_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  brStrobes_t        strobes,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] prevFetchAddr,
  input  logic [PTR_W-1:0]  issueCnt,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [PTR_W-1:0]  ptrVal,
  output logic [ADDR_W-1:0] priorAddr,
  output logic              priorValid
);
  logic              hasCapture;
  logic [ADDR_W-1:0] backOffset;
  logic              unusedBits;

  assign unusedBits = ^prevFetchAddr[1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr    <= '0;
      dstAddr    <= '0;
      ptrVal     <= '0;
      hasCapture <= 1'b0;
    end else if (strobes.capture) begin
      dstAddr    <= {fetchAddr[ADDR_W-1:1], 1'b0};
      hasCapture <= 1'b1;
      if (strobes.useTarget) begin
        srcAddr <= {fetchAddr[ADDR_W-1:1], 1'b0};
        ptrVal  <= '0;
      end else begin
        srcAddr <= {prevFetchAddr[ADDR_W-1:2], 2'b00};
        ptrVal  <= issueCnt;
      end
    end
  end

  always_comb begin
    backOffset = ADDR_W'(ptrVal) << 1;
    priorValid = hasCapture & ~srcAddr[1];
    priorAddr  = srcAddr[1] ? srcAddr : (srcAddr - backOffset);
  end

  // R4
  dst_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> dstAddr == {$past(fetchAddr[ADDR_W-1:1]), 1'b0});

  // R6
  delayed_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.useTarget |=> (srcAddr == dstAddr && ptrVal == '0));

  // R5
  normal_src_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.useTarget) |=> (srcAddr[1:0] == 2'b00 && ptrVal == $past(issueCnt)));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(srcAddr) && $stable(dstAddr) && $stable(ptrVal)));
endmodule

// File: rtl/branch_trace_capture.sv
module branch_trace_capture
  import brtrace_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceEn,
  input  logic              brStrobe,
  input  logic [1:0]        brKind,
  input  logic [31:0]       fetchAddr,
  input  logic [31:0]       prevFetchAddr,
  input  logic [1:0]        issueCnt,
  input  logic              delayedBr,
  output logic [31:0]       srcAddr,
  output logic [31:0]       dstAddr,
  output logic [1:0]        ptrVal,
  output logic [31:0]       priorAddr,
  output logic              priorValid
);
  brStrobes_t strobes;

  brtrace_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .traceEn      (traceEn),
    .brStrobe     (brStrobe),
    .brKind       (brKind),
    .delayedBr    (delayedBr),
    .targetHalfBit(fetchAddr[1]),
    .strobes      (strobes)
  );

  brtrace_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .fetchAddr    (fetchAddr),
    .prevFetchAddr(prevFetchAddr),
    .issueCnt     (issueCnt),
    .srcAddr      (srcAddr),
    .dstAddr      (dstAddr),
    .ptrVal       (ptrVal),
    .priorAddr    (priorAddr),
    .priorValid   (priorValid)
  );

  // R8
  valid_excludes_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    priorValid |-> !srcAddr[1]);

  // R4
  addr_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srcAddr[0] && !dstAddr[0]));

  // R7
  invalid_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcAddr[1] |-> (priorAddr == srcAddr && !priorValid));
endmodule

// File: tb/branch_trace_capture_bench.sv
`timescale 1ns/1ps
module branch_trace_capture_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        traceEn = 1'b0, brStrobe = 1'b0, delayedBr = 1'b0;
  logic [1:0]  brKind = '0, issueCnt = '0;
  logic [31:0] fetchAddr = '0, prevFetchAddr = '0;
  logic [31:0] srcAddr, dstAddr, priorAddr;
  logic [1:0]  ptrVal;
  logic        priorValid;

  int checks = 0;
  int failures = 0;
  logic [31:0] mSrc = '0, mDst = '0;
  logic [1:0]  mPtr = '0;
  logic        mHas = 1'b0;

  always #2.5 clk = ~clk;

  branch_trace_capture u_branch_trace_capture (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .brStrobe(brStrobe),
    .brKind(brKind), .fetchAddr(fetchAddr), .prevFetchAddr(prevFetchAddr),
    .issueCnt(issueCnt), .delayedBr(delayedBr), .srcAddr(srcAddr),
    .dstAddr(dstAddr), .ptrVal(ptrVal), .priorAddr(priorAddr),
    .priorValid(priorValid)
  );

  function automatic logic [31:0] expPrior(logic [31:0] s, logic [1:0] p);
    if (s[1]) return s;
    return s - {29'd0, p, 1'b0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    check({req, " src"}, srcAddr, mSrc);
    check({req, " dst"}, dstAddr, mDst);
    check({req, " ptr"}, {30'd0, ptrVal}, {30'd0, mPtr});
    check({req, " R7 prior"}, priorAddr, expPrior(mSrc, mPtr));
    check({req, " R8 valid"}, {31'd0, priorValid}, {31'd0, mHas & ~mSrc[1]});
  endtask

  task automatic step(logic en, logic stb, logic [1:0] k, logic [31:0] fa,
                      logic [31:0] pa, logic [1:0] ic, logic db, string req);
    traceEn = en; brStrobe = stb; brKind = k; fetchAddr = fa;
    prevFetchAddr = pa; issueCnt = ic; delayedBr = db;
    @(posedge clk);
    if (en && stb && k != 2'd3) begin
      mDst = {fa[31:1], 1'b0};
      mHas = 1'b1;
      if (db && fa[1]) begin mSrc = {fa[31:1], 1'b0}; mPtr = 2'd0; end
      else begin mSrc = {pa[31:2], 2'b00}; mPtr = ic; end
    end
    @(negedge clk);
    brStrobe = 1'b0;
    checkAll(req);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");
    // R2: tracing off and reserved kind leave the record untouched
    step(1'b0, 1'b1, 2'd0, 32'h1000_0010, 32'h2000_0004, 2'd1, 1'b0, "R2 traceoff");
    step(1'b1, 1'b1, 2'd3, 32'h1000_0010, 32'h2000_0004, 2'd1, 1'b0, "R2 reserved");
    // R3: each kind captures
    step(1'b1, 1'b1, 2'd0, 32'h0000_1235, 32'h0000_4447, 2'd2, 1'b0, "R3 R4 R5 branch");
    step(1'b1, 1'b1, 2'd1, 32'h0000_8000, 32'h0000_900C, 2'd1, 1'b0, "R3 R9 repeat");
    step(1'b1, 1'b1, 2'd2, 32'hFFFF_FFF0, 32'h0000_0020, 2'd3, 1'b0, "R3 interrupt");
    step(1'b0, 1'b1, 2'd1, 32'h0000_0040, 32'h0000_0050, 2'd0, 1'b0, "R2 traceoff2");
    // R6: delayed branch to 4n+2, then delayed to 4n
    step(1'b1, 1'b1, 2'd0, 32'h0000_3006, 32'h0000_2008, 2'd3, 1'b1, "R6 delayed 4n+2");
    step(1'b1, 1'b1, 2'd0, 32'h0000_3008, 32'h0000_2008, 2'd2, 1'b1, "R6 delayed 4n");
    // R7: wrap below zero
    step(1'b1, 1'b1, 2'd2, 32'h0000_0100, 32'h0000_0002, 2'd3, 1'b0, "R7 wrap");
    for (int i = 0; i < 300; i++) begin
      step(($urandom % 8) != 0, ($urandom % 3) != 0, 2'($urandom),
           $urandom, $urandom, 2'($urandom), ($urandom % 2) == 1, "R9 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule